// File: doc/BRIEF.md
# Triggered Framed Serial Word Transmitter

This block sends words taken from a first-word-fall-through transmit FIFO as a pair of lines: a bit clock and a data line. A run begins on a software start pulse or on an edge of an external trigger. The edge polarity is selectable, and the trigger can be switched off. Once started, the engine waits a programmable number of cycles. It then shifts out a 16- or 32-bit word in either bit order, with an optional parity bit appended in the same clock burst. In single-cycle mode one word is sent per start. In multi-cycle mode words are sent until the FIFO runs dry, with a programmable idle gap between them.

When the last word has gone, a programmable delay elapses and then a done pulse of programmable width appears. An outgoing trigger pulse of programmable width marks each accepted start. The bit clock half-period is either a fixed divider of the system clock (a 1 MHz bit rate from 50 MHz by default) or a programmable divider. All delays are counted in system clock cycles.

Top module: `fwt_tx`

## Requirements
- R1: After reset, `ser_clk`, `ser_dat`, `done_pulse`, `trig_out` and `fifo_pop` are all low, and they stay low until a start is accepted.
- R2: An idle engine starts on `sw_start` high at a clock edge. It also starts on an edge of `ext_trig` when `cfg_trig_en` is 1: a rising edge when `cfg_trig_pol` is 0, a falling edge when it is 1. With `cfg_trig_en` at 0, `ext_trig` has no effect.
- R3: The first rising edge of `ser_clk` comes exactly `cfg_pre_dly` + 1 + H cycles after the start edge, where H is the half-period.
- R4: H is `FIXED_HALF` (25) when `cfg_rate_fixed` is 1. Otherwise it is `cfg_half`, with 0 read as 1. Within a word, rising edges of `ser_clk` are 2H cycles apart. `ser_dat` changes only while `ser_clk` is low, and the receiver samples it on the rising edge.
- R5: With `cfg_long_word` at 1 a word carries all 32 bits of `fifo_data`. With it at 0 a word carries bits 15..0 only.
- R6: With `cfg_msb_first` at 1 the highest data bit goes first. With it at 0 bit 0 goes first.
- R7: `cfg_parity` selects the parity bit: 1 even, 2 odd, 0 or 3 none. The parity bit covers the sent data bits and is clocked out right after the last data bit, with no gap.
- R8: With `cfg_multi` at 0 exactly one word is popped and sent per start. Further FIFO words stay in the FIFO.
- R9: With `cfg_multi` at 1 words are popped and sent until the FIFO is empty. From the last rising edge of one word to the first rising edge of the next is 2H + `cfg_gap` + 1 cycles. `fifo_pop` is never high while the FIFO is empty.
- R10: `done_pulse` rises `cfg_done_dly` + 1 cycles after `ser_clk` falls at the end of the last bit, and stays high for `cfg_done_w` cycles, with 0 read as 1. If the FIFO is empty when the pre-delay ends, no bit is sent and `done_pulse` rises `cfg_pre_dly` + `cfg_done_dly` + 2 cycles after the start edge. Both lines stay low while `done_pulse` is high.
- R11: Each accepted start raises `trig_out` at the start edge for `cfg_trig_w` cycles. A width of 0 gives no pulse.
- R12: A start request made while a run is in progress, up to the end of its done pulse, is ignored. It produces no extra trigger pulse, no extra bits and no extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_start | input | 1 | Software start request |
| ext_trig | input | 1 | External trigger line |
| cfg_trig_en | input | 1 | Enable starts from the external trigger |
| cfg_trig_pol | input | 1 | 0: rising edge starts, 1: falling edge starts |
| cfg_long_word | input | 1 | 1: 32-bit words, 0: 16-bit words |
| cfg_msb_first | input | 1 | 1: most significant bit first |
| cfg_parity | input | 2 | 1 even, 2 odd, else none |
| cfg_multi | input | 1 | 1: send until FIFO empty, 0: one word per start |
| cfg_rate_fixed | input | 1 | 1: fixed half-period, 0: programmable |
| cfg_half | input | DIV_W | Programmable half-period in cycles |
| cfg_pre_dly | input | CNT_W | Pre-data delay |
| cfg_gap | input | CNT_W | Gap between words |
| cfg_done_dly | input | CNT_W | Delay before done pulse |
| cfg_done_w | input | CNT_W | Done pulse width |
| cfg_trig_w | input | CNT_W | Outgoing trigger pulse width |
| fifo_data | input | WORD_W | Head word of the transmit FIFO |
| fifo_empty | input | 1 | Transmit FIFO empty |
| fifo_pop | output | 1 | Consume the head word this cycle |
| ser_clk | output | 1 | Serial bit clock |
| ser_dat | output | 1 | Serial data |
| done_pulse | output | 1 | End-of-run pulse |
| trig_out | output | 1 | Outgoing trigger pulse |

## Verification
The properties assume that the configuration inputs hold steady from an accepted start to the end of its done pulse. They also assume the FIFO behaves as a first-word-fall-through queue that can never empty without a pop. The bench changes configuration only while the engine is idle. Its FIFO model is fed only between runs and advances only on `fifo_pop`. Before enabling the external trigger, it parks `ext_trig` at the inactive level for several cycles, so that no false edge is seen.

// File: rtl/fwt_pkg.sv
package fwt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SHIFT,
        ST_GAP,
        ST_DWAIT,
        ST_DPULSE
    } fwt_state_e;

    localparam logic [1:0] PAR_EVEN = 2'd1;
    localparam logic [1:0] PAR_ODD  = 2'd2;
endpackage

// File: rtl/fwt_start_det.sv
module fwt_start_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_start,
    input  logic ext_trig,
    input  logic trig_en,
    input  logic trig_pol,
    output logic start
);
    logic prev_d, prev_q;
    logic edge_hit;

    always_comb begin
        prev_d   = ext_trig;
        edge_hit = trig_pol ? (prev_q & ~ext_trig) : (~prev_q & ext_trig);
        start    = sw_start | (trig_en & edge_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/fwt_framer.sv
module fwt_framer #(
    parameter int WORD_W  = 32,
    parameter int SHORT_W = 16,
    parameter int FRAME_W = WORD_W + 1,
    parameter int BIT_CW  = 6
) (
    input  logic [WORD_W-1:0]  data,
    input  logic               long_word,
    input  logic               msb_first,
    input  logic [1:0]         par_mode,
    output logic [FRAME_W-1:0] frame,
    output logic [BIT_CW-1:0]  last_idx
);
    import fwt_pkg::*;

    int   n;
    logic has_par;
    logic acc;

    always_comb begin
        n       = long_word ? WORD_W : SHORT_W;
        has_par = (par_mode == PAR_EVEN) || (par_mode == PAR_ODD);
        acc     = (par_mode == PAR_ODD);
        frame   = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (i < n) begin
                acc      = acc ^ data[i];
                frame[i] = msb_first ? data[n - 1 - i] : data[i];
            end
        end
        for (int i = 0; i < FRAME_W; i++) begin
            if (i == n && has_par) frame[i] = acc;
        end
        last_idx = BIT_CW'(n - 1 + (has_par ? 1 : 0));
    end
endmodule

// File: rtl/fwt_pulse.sv
module fwt_pulse #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [CNT_W-1:0] width,
    output logic             pulse
);
    logic             act_d, act_q;
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        act_d = act_q;
        cnt_d = cnt_q;
        if (act_q) begin
            if (cnt_q == '0) act_d = 1'b0;
            else             cnt_d = cnt_q - CNT_W'(1);
        end
        if (fire && width != '0) begin
            act_d = 1'b1;
            cnt_d = width - CNT_W'(1);
        end
        pulse = act_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            act_q <= act_d;
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/fwt_tx.sv
module fwt_tx #(
    parameter int WORD_W     = 32,
    parameter int SHORT_W    = 16,
    parameter int CNT_W      = 16,
    parameter int DIV_W      = 8,
    parameter int FIXED_HALF = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_start,
    input  logic              ext_trig,
    input  logic              cfg_trig_en,
    input  logic              cfg_trig_pol,
    input  logic              cfg_long_word,
    input  logic              cfg_msb_first,
    input  logic [1:0]        cfg_parity,
    input  logic              cfg_multi,
    input  logic              cfg_rate_fixed,
    input  logic [DIV_W-1:0]  cfg_half,
    input  logic [CNT_W-1:0]  cfg_pre_dly,
    input  logic [CNT_W-1:0]  cfg_gap,
    input  logic [CNT_W-1:0]  cfg_done_dly,
    input  logic [CNT_W-1:0]  cfg_done_w,
    input  logic [CNT_W-1:0]  cfg_trig_w,
    input  logic [WORD_W-1:0] fifo_data,
    input  logic              fifo_empty,
    output logic              fifo_pop,
    output logic              ser_clk,
    output logic              ser_dat,
    output logic              done_pulse,
    output logic              trig_out
);
    import fwt_pkg::*;

    localparam int FRAME_W = WORD_W + 1;
    localparam int BIT_CW  = $clog2(FRAME_W + 1);
    localparam logic [DIV_W-1:0] FIXED_H = DIV_W'(FIXED_HALF);

    typedef struct packed {
        fwt_state_e         st;
        logic [CNT_W-1:0]   cnt;
        logic [DIV_W-1:0]   hcnt;
        logic [BIT_CW-1:0]  bits;
        logic [FRAME_W-1:0] sh;
        logic               sclk;
        logic               sdat;
        logic               done;
    } tx_s;

    tx_s q_q, q_d;

    logic               start_req;
    logic               accept;
    logic [FRAME_W-1:0] frame;
    logic [BIT_CW-1:0]  last_idx;
    logic [DIV_W-1:0]   half_v, half_m1;
    logic               do_fetch;

    fwt_start_det u_start (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_start (sw_start),
        .ext_trig (ext_trig),
        .trig_en  (cfg_trig_en),
        .trig_pol (cfg_trig_pol),
        .start    (start_req)
    );

    fwt_framer #(
        .WORD_W  (WORD_W),
        .SHORT_W (SHORT_W),
        .FRAME_W (FRAME_W),
        .BIT_CW  (BIT_CW)
    ) u_framer (
        .data      (fifo_data),
        .long_word (cfg_long_word),
        .msb_first (cfg_msb_first),
        .par_mode  (cfg_parity),
        .frame     (frame),
        .last_idx  (last_idx)
    );

    fwt_pulse #(.CNT_W(CNT_W)) u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (accept),
        .width (cfg_trig_w),
        .pulse (trig_out)
    );

    always_comb begin
        q_d      = q_q;
        fifo_pop = 1'b0;
        do_fetch = 1'b0;
        accept   = start_req && (q_q.st == ST_IDLE);
        half_v   = cfg_rate_fixed ? FIXED_H
                 : ((cfg_half == '0) ? DIV_W'(1) : cfg_half);
        half_m1  = half_v - DIV_W'(1);

        case (q_q.st)
            ST_IDLE: begin
                if (accept) begin
                    q_d.st  = ST_PRE;
                    q_d.cnt = cfg_pre_dly;
                end
            end
            ST_PRE, ST_GAP: begin
                if (q_q.cnt == '0) do_fetch = 1'b1;
                else               q_d.cnt  = q_q.cnt - CNT_W'(1);
            end
            ST_SHIFT: begin
                if (q_q.hcnt != '0) begin
                    q_d.hcnt = q_q.hcnt - DIV_W'(1);
                end else if (!q_q.sclk) begin
                    q_d.sclk = 1'b1;
                    q_d.hcnt = half_m1;
                end else if (q_q.bits != '0) begin
                    q_d.sh   = q_q.sh >> 1;
                    q_d.sdat = q_q.sh[1];
                    q_d.sclk = 1'b0;
                    q_d.hcnt = half_m1;
                    q_d.bits = q_q.bits - BIT_CW'(1);
                end else begin
                    q_d.sclk = 1'b0;
                    q_d.sdat = 1'b0;
                    if (cfg_multi && !fifo_empty) begin
                        q_d.st  = ST_GAP;
                        q_d.cnt = cfg_gap;
                    end else begin
                        q_d.st  = ST_DWAIT;
                        q_d.cnt = cfg_done_dly;
                    end
                end
            end
            ST_DWAIT: begin
                if (q_q.cnt == '0) begin
                    q_d.st   = ST_DPULSE;
                    q_d.done = 1'b1;
                    q_d.cnt  = (cfg_done_w == '0) ? '0 : cfg_done_w - CNT_W'(1);
                end else begin
                    q_d.cnt = q_q.cnt - CNT_W'(1);
                end
            end
            ST_DPULSE: begin
                if (q_q.cnt == '0) begin
                    q_d.st   = ST_IDLE;
                    q_d.done = 1'b0;
                end else begin
                    q_d.cnt = q_q.cnt - CNT_W'(1);
                end
            end
            default: q_d.st = ST_IDLE;
        endcase

        if (do_fetch) begin
            if (!fifo_empty) begin
                fifo_pop  = 1'b1;
                q_d.st    = ST_SHIFT;
                q_d.sh    = frame;
                q_d.sdat  = frame[0];
                q_d.sclk  = 1'b0;
                q_d.hcnt  = half_m1;
                q_d.bits  = last_idx;
            end else begin
                q_d.st  = ST_DWAIT;
                q_d.cnt = cfg_done_dly;
            end
        end

        ser_clk    = q_q.sclk;
        ser_dat    = q_q.sdat;
        done_pulse = q_q.done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '{st: ST_IDLE, default: '0};
        end else begin
            q_q <= q_d;
        end
    end
endmodule

// File: rtl/fwt_tx_chk.sv
module fwt_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic fifo_pop,
    input logic fifo_empty,
    input logic ser_clk,
    input logic ser_dat,
    input logic done_pulse,
    input logic trig_out
);
    a_r9_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    a_r4_data_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser_dat) |-> !ser_clk);

    a_r10_done_lines_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (!ser_clk && !ser_dat));

    a_r4_load_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> !ser_clk);

    a_r10_done_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> !fifo_pop);

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!ser_clk && !done_pulse && !trig_out));
endmodule

bind fwt_tx fwt_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_pop   (fifo_pop),
    .fifo_empty (fifo_empty),
    .ser_clk    (ser_clk),
    .ser_dat    (ser_dat),
    .done_pulse (done_pulse),
    .trig_out   (trig_out)
);

// File: tb/fwt_tx_test.sv
module fwt_tx_test;
    localparam int WORD_W = 32;
    localparam int CNT_W  = 16;
    localparam int DIV_W  = 8;
    localparam int FIXED  = 25;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, sw_start, ext_trig, cfg_trig_en, cfg_trig_pol, cfg_long_word;
    logic cfg_msb_first, cfg_multi, cfg_rate_fixed;
    logic [1:0] cfg_parity;
    logic [DIV_W-1:0] cfg_half;
    logic [CNT_W-1:0] cfg_pre_dly, cfg_gap, cfg_done_dly, cfg_done_w, cfg_trig_w;
    logic [WORD_W-1:0] fifo_data;
    logic fifo_empty, fifo_pop, ser_clk, ser_dat, done_pulse, trig_out;

    fwt_tx uut (
        .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .ext_trig(ext_trig),
        .cfg_trig_en(cfg_trig_en), .cfg_trig_pol(cfg_trig_pol),
        .cfg_long_word(cfg_long_word), .cfg_msb_first(cfg_msb_first),
        .cfg_parity(cfg_parity), .cfg_multi(cfg_multi),
        .cfg_rate_fixed(cfg_rate_fixed), .cfg_half(cfg_half),
        .cfg_pre_dly(cfg_pre_dly), .cfg_gap(cfg_gap),
        .cfg_done_dly(cfg_done_dly), .cfg_done_w(cfg_done_w),
        .cfg_trig_w(cfg_trig_w), .fifo_data(fifo_data),
        .fifo_empty(fifo_empty), .fifo_pop(fifo_pop), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .done_pulse(done_pulse), .trig_out(trig_out)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // FIFO model: first-word-fall-through
    logic [31:0] fmem [0:63];
    int  wr_p = 0;
    int  rd_p = 0;
    logic flush = 1'b0;
    assign fifo_empty = (rd_p == wr_p);
    assign fifo_data  = fmem[rd_p & 63];
    always @(posedge clk) begin
        if (flush)         rd_p <= wr_p;
        else if (fifo_pop) rd_p <= rd_p + 1;
    end

    // Monitor
    logic rbit [0:511];
    int   rt   [0:511];
    int   nr, last_fall, done_rise, done_len, done_n, trig_rise, trig_len, trig_n;
    logic p_clk = 1'b0, p_done = 1'b0, p_trig = 1'b0;

    always @(negedge clk) begin
        if (ser_clk && !p_clk) begin
            if (nr < 512) begin
                rbit[nr] = ser_dat;
                rt[nr]   = cyc;
            end
            nr++;
        end
        if (!ser_clk && p_clk) last_fall = cyc;
        if (done_pulse) begin
            if (!p_done) begin done_rise = cyc; done_n++; end
            done_len++;
        end
        if (trig_out) begin
            if (!p_trig) begin trig_rise = cyc; trig_n++; end
            trig_len++;
        end
        p_clk  = ser_clk;
        p_done = done_pulse;
        p_trig = trig_out;
    end

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        nr = 0; last_fall = -1; done_rise = -1; done_len = 0; done_n = 0;
        trig_rise = -1; trig_len = 0; trig_n = 0;
    endtask

    function automatic logic exp_bit(input logic [31:0] w, input logic lw, input logic msb,
                                     input logic [1:0] par, input int i);
        int n = lw ? 32 : 16;
        logic p = (par == 2'd2);
        if (i < n) return msb ? w[n-1-i] : w[i];
        for (int k = 0; k < n; k++) p ^= w[k];
        return p;
    endfunction

    task automatic run(input string req, input logic lw, input logic msb, input logic [1:0] par,
                       input logic multi, input logic fixed, input int half, input int pre,
                       input int gap, input int dd, input int dw, input int tw,
                       input int nwords, input logic use_ext, input logic pol,
                       input logic poke);
        logic [31:0] w [0:7];
        int h, nb, sent, t0, berr, terr, base, exp_done, poked, k;
        @(negedge clk);
        flush = 1'b1;
        cfg_long_word = lw; cfg_msb_first = msb; cfg_parity = par; cfg_multi = multi;
        cfg_rate_fixed = fixed; cfg_half = DIV_W'(half); cfg_pre_dly = CNT_W'(pre);
        cfg_gap = CNT_W'(gap); cfg_done_dly = CNT_W'(dd); cfg_done_w = CNT_W'(dw);
        cfg_trig_w = CNT_W'(tw); cfg_trig_pol = pol; cfg_trig_en = use_ext;
        ext_trig = pol;
        @(negedge clk);
        flush = 1'b0;
        for (int i = 0; i < nwords; i++) begin
            w[i] = $urandom;
            fmem[wr_p & 63] = w[i];
            wr_p++;
        end
        repeat (3) @(negedge clk);
        @(posedge clk);
        clear_mon();
        @(negedge clk);
        t0 = cyc + 1;
        if (use_ext) ext_trig = ~pol; else sw_start = 1'b1;
        poked = 0;
        k = 0;
        while (!(done_n > 0 && !done_pulse) && k < 20000) begin
            @(negedge clk);
            if (poke && poked == 0 && nr >= 3) begin
                sw_start = 1'b1;
                poked = 1;
            end else begin
                sw_start = 1'b0;
            end
            k++;
        end
        sw_start = 1'b0;
        ext_trig = pol;
        h    = fixed ? FIXED : (half == 0 ? 1 : half);
        nb   = (lw ? 32 : 16) + ((par == 2'd1 || par == 2'd2) ? 1 : 0);
        sent = (nwords == 0) ? 0 : (multi ? nwords : 1);
        base = t0 + pre + 1 + h;
        chk(req, "bit count", nr, sent * nb);
        berr = 0; terr = 0;
        for (int j = 0; j < sent; j++) begin
            for (int b = 0; b < nb; b++) begin
                int idx = j * nb + b;
                if (idx < nr && idx < 512) begin
                    if (rbit[idx] !== exp_bit(w[j], lw, msb, par, b)) berr++;
                    if (rt[idx] != base + j * (nb * 2 * h + gap + 1) + b * 2 * h) terr++;
                end
            end
        end
        chk(req, "bit value mismatches", berr, 0);
        chk(req, "clock edge timing mismatches", terr, 0);
        exp_done = (sent == 0) ? t0 + pre + dd + 2
                 : base + (sent - 1) * (nb * 2 * h + gap + 1) + (nb - 1) * 2 * h + h + dd + 1;
        chk(req, "done rise cycle", done_rise, exp_done);
        chk(req, "done width", done_len, dw == 0 ? 1 : dw);
        chk(req, "done pulses", done_n, 1);
        chk(req, "trigger pulses", trig_n, tw == 0 ? 0 : 1);
        chk(req, "trigger width", trig_len, tw);
        if (tw != 0) chk(req, "trigger rise cycle", trig_rise, t0);
        chk(req, "words left in FIFO", wr_p - rd_p, nwords - sent);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        rst_n = 1'b0; sw_start = 1'b0; ext_trig = 1'b0; cfg_trig_en = 1'b0;
        cfg_trig_pol = 1'b0; cfg_long_word = 1'b0; cfg_msb_first = 1'b0;
        cfg_parity = 2'd0; cfg_multi = 1'b0; cfg_rate_fixed = 1'b0; cfg_half = '0;
        cfg_pre_dly = '0; cfg_gap = '0; cfg_done_dly = '0; cfg_done_w = '0; cfg_trig_w = '0;
        clear_mon();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: quiet after reset
        chk("R1", "ser_clk", int'(ser_clk), 0);
        chk("R1", "ser_dat", int'(ser_dat), 0);
        chk("R1", "done_pulse", int'(done_pulse), 0);
        chk("R1", "trig_out", int'(trig_out), 0);
        chk("R1", "fifo_pop", int'(fifo_pop), 0);

        // R8 R5 R3: single word, 16-bit, LSB first, two words queued
        run("R8", 0, 0, 2'd0, 0, 0, 2, 3, 0, 2, 3, 2, 2, 0, 0, 0);
        // R9 R6 R7: multi-cycle, 32-bit, MSB first, even parity
        run("R9", 1, 1, 2'd1, 1, 0, 1, 0, 4, 1, 2, 1, 3, 0, 0, 0);
        // R4 R7: fixed rate, odd parity
        run("R4", 0, 1, 2'd2, 0, 1, 0, 1, 0, 0, 1, 0, 1, 0, 0, 0);
        // R2: external rising edge, then falling edge
        run("R2", 0, 0, 2'd3, 0, 0, 3, 2, 0, 1, 1, 2, 1, 1, 0, 0);
        run("R2", 1, 0, 2'd0, 1, 0, 1, 1, 0, 0, 2, 1, 2, 1, 1, 0);
        // R10: empty FIFO at end of pre-delay
        run("R10", 0, 0, 2'd0, 1, 0, 2, 5, 1, 3, 2, 1, 0, 0, 0, 0);
        // R12: start while busy is ignored
        run("R12", 0, 0, 2'd1, 0, 0, 2, 1, 0, 1, 2, 2, 2, 0, 0, 1);
        // R11 R10: zero widths
        run("R11", 0, 1, 2'd0, 0, 0, 1, 0, 0, 0, 0, 0, 1, 0, 0, 0);

        // R2: external trigger disabled
        begin
            @(negedge clk);
            cfg_trig_en = 1'b0; cfg_trig_pol = 1'b0; cfg_trig_w = CNT_W'(3);
            cfg_pre_dly = '0; cfg_multi = 1'b0; ext_trig = 1'b0;
            fmem[wr_p & 63] = 32'h1234_5678; wr_p++;
            repeat (3) @(negedge clk);
            @(posedge clk);
            clear_mon();
            @(negedge clk);
            ext_trig = 1'b1;
            repeat (40) @(negedge clk);
            ext_trig = 1'b0;
            chk("R2", "disabled trigger: trig pulses", trig_n, 0);
            chk("R2", "disabled trigger: clock edges", nr, 0);
            chk("R2", "disabled trigger: words left", wr_p - rd_p, 1);
        end

        // Random mix
        for (int it = 0; it < 10; it++) begin
            logic e;
            e = 1'($urandom_range(0, 1));
            run(e ? "R2" : "R3", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'b0,
                int'($urandom_range(0, 3)), int'($urandom_range(0, 7)),
                int'($urandom_range(0, 5)), int'($urandom_range(0, 5)),
                int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                int'($urandom_range(1, 3)), e, 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)));
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > 180000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule